// File: doc/BRIEF.md
# Quadrature Encoder Decoder

This block turns the two phase signals and the index signal of an incremental rotary encoder into a position, a revolution count and a speed figure. Each of the three inputs first goes through a glitch filter. The filter's delay is set in clock cycles. The two filtered phases are then decoded into count events with a direction. The decoder counts either on edges of phase A only (2X) or on edges of both phases (4X).

The position counter wraps inside a programmable range. A revolution counter advances on every filtered index pulse. A window timer reloads itself, and at the end of each window it latches the number of edges seen in that window. Sticky status flags report four conditions:
- the position reaching its compare value;
- the index count reaching its compare value;
- both compare values being met together;
- the end of a velocity window.

A fifth flag reports an illegal phase transition. Software sets up the block and reads results through a small register port with a single-cycle write and a combinational read.

Top module: `qenc_decoder`

## Requirements
- R1: After reset, position (addr 8), index count (addr 9), sticky status bits [4:0] (addr 7) and `irq_o` all read 0.
- R2: With a filter delay D (addr 1), a filtered input takes a new raw value only after the raw input has held that value for D+1 consecutive clocks. A pulse of D clocks or fewer is ignored.
- R3: Control bit 0 (addr 0) selects the counting mode. At 1 (4X), every filtered edge of either phase counts. At 0 (2X), only edges of phase A count, and a lone phase B edge leaves the position unchanged.
- R4: The phase states (A,B) form the cycle 00, 10, 11, 01. Stepping forward through it (A leading B) adds one per counted edge, and stepping backward subtracts one. Status bit 5 shows the direction of the last count (1 = up).
- R5: If both filtered phases change in the same cycle, status bit 4 is set and the position does not change.
- R6: Counting up from the maximum (addr 2) gives 0. Counting down from 0 gives the maximum.
- R7: The index count (addr 9) goes up by one on each rising edge of the filtered index input.
- R8: The window timer has a reload value R (addr 5; writing it restarts the window). Every R+1 clocks the edge count of the window is copied to addr 10, the edge count is cleared, and status bit 3 is set.
- R9: Status bit 0 is set when a count event leaves the position equal to its compare value (addr 3). Bit 1 is set when an index edge leaves the index count equal to its compare value (addr 4). Bit 2 is set when either event leaves both equal to their compare values.
- R10: `irq_o` is high when any status bit [4:0] is set and its enable bit (addr 6) is also set. Writing 1s to addr 7 clears those status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Encoder index pulse |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the encoder inputs are at 0 during reset. They also assume the configuration registers are not rewritten while the encoder is moving. The bench holds all three inputs low through reset and changes the configuration only between movement sequences.

The phases move in one of two ways. Random legal steps along the gray cycle keep the phases at least D+3 clocks apart, so the filter always passes each step. Deliberate glitches and double-phase flips are driven separately, to exercise the filter and the error flag.

// File: rtl/qenc_decoder.sv
module qenc_decoder #(
  parameter int POS_W  = 16,
  parameter int CNT_W  = 16,
  parameter int FILT_W = 8,
  parameter int TMR_W  = 16,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_a,
  input  logic          enc_b,
  input  logic          enc_idx,
  input  logic [3:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);
  localparam int NIN = 3;
  localparam int NST = 5;

  logic              mode4x;
  logic [FILT_W-1:0] flt_dly;
  logic [POS_W-1:0]  pos_max, pos_cmp, pos;
  logic [CNT_W-1:0]  idx_cmp, idx_cnt, edge_cnt, vel_cap;
  logic [TMR_W-1:0]  win_reload, win_tmr;
  logic [NST-1:0]    irq_en, status;
  logic              dir_up;

  logic [NIN-1:0]    raw, filt, filt_q;
  logic [FILT_W-1:0] fcnt [NIN];

  assign raw = {enc_idx, enc_b, enc_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt   <= '0;
      filt_q <= '0;
      for (int i = 0; i < NIN; i++) fcnt[i] <= '0;
    end else begin
      filt_q <= filt;
      for (int i = 0; i < NIN; i++) begin
        if (raw[i] == filt[i]) fcnt[i] <= '0;
        else if (fcnt[i] >= flt_dly) begin
          filt[i] <= raw[i];
          fcnt[i] <= '0;
        end else fcnt[i] <= fcnt[i] + 1'b1;
      end
    end
  end

  wire ch_a     = filt[0] ^ filt_q[0];
  wire ch_b     = filt[1] ^ filt_q[1];
  wire illegal  = ch_a & ch_b;
  wire step_up  = filt[0] ^ filt_q[1];
  wire cnt_ev   = !illegal && (ch_a || (mode4x && ch_b));
  wire idx_rise = filt[2] & ~filt_q[2];
  wire win_end  = (win_tmr == '0);

  logic [POS_W-1:0] pos_n;
  always_comb begin
    pos_n = pos;
    if (cnt_ev) begin
      if (step_up) pos_n = (pos >= pos_max) ? '0 : pos + 1'b1;
      else         pos_n = (pos == '0) ? pos_max : pos - 1'b1;
    end
  end
  wire [CNT_W-1:0] idx_n = idx_rise ? idx_cnt + 1'b1 : idx_cnt;

  wire pm_hit   = cnt_ev && (pos_n == pos_cmp);
  wire im_hit   = idx_rise && (idx_n == idx_cmp);
  wire both_hit = (cnt_ev || idx_rise) && (pos_n == pos_cmp) && (idx_n == idx_cmp);
  wire [NST-1:0] st_set = {illegal, win_end, both_hit, im_hit, pm_hit};
  wire wr_st = reg_wr && (reg_addr == 4'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode4x     <= 1'b0;
      flt_dly    <= '0;
      pos_max    <= '1;
      pos_cmp    <= '0;
      idx_cmp    <= '0;
      win_reload <= '1;
      win_tmr    <= '1;
      irq_en     <= '0;
      status     <= '0;
      pos        <= '0;
      idx_cnt    <= '0;
      edge_cnt   <= '0;
      vel_cap    <= '0;
      dir_up     <= 1'b0;
    end else begin
      pos     <= pos_n;
      idx_cnt <= idx_n;
      if (cnt_ev) dir_up <= step_up;
      if (win_end) begin
        vel_cap  <= edge_cnt;
        edge_cnt <= cnt_ev ? CNT_W'(1) : '0;
        win_tmr  <= win_reload;
      end else begin
        if (cnt_ev) edge_cnt <= edge_cnt + 1'b1;
        win_tmr <= win_tmr - 1'b1;
      end
      status <= (status & ~(wr_st ? reg_wdata[NST-1:0] : '0)) | st_set;
      if (reg_wr) begin
        case (reg_addr)
          4'd0: mode4x  <= reg_wdata[0];
          4'd1: flt_dly <= reg_wdata[FILT_W-1:0];
          4'd2: pos_max <= reg_wdata[POS_W-1:0];
          4'd3: pos_cmp <= reg_wdata[POS_W-1:0];
          4'd4: idx_cmp <= reg_wdata[CNT_W-1:0];
          4'd5: begin
            win_reload <= reg_wdata[TMR_W-1:0];
            win_tmr    <= reg_wdata[TMR_W-1:0];
          end
          4'd6: irq_en  <= reg_wdata[NST-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0:  reg_rdata = DW'(mode4x);
      4'd1:  reg_rdata = DW'(flt_dly);
      4'd2:  reg_rdata = DW'(pos_max);
      4'd3:  reg_rdata = DW'(pos_cmp);
      4'd4:  reg_rdata = DW'(idx_cmp);
      4'd5:  reg_rdata = DW'(win_reload);
      4'd6:  reg_rdata = DW'(irq_en);
      4'd7:  reg_rdata = DW'({dir_up, status});
      4'd8:  reg_rdata = DW'(pos);
      4'd9:  reg_rdata = DW'(idx_cnt);
      4'd10: reg_rdata = DW'(vel_cap);
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o = |(status & irq_en);
endmodule

// File: rtl/qenc_decoder_chk.sv
module qenc_decoder_chk #(
  parameter int POS_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode4x,
  input logic [2:0]       raw,
  input logic [2:0]       filt,
  input logic [2:0]       filt_q,
  input logic [POS_W-1:0] pos,
  input logic [POS_W-1:0] pos_max,
  input logic [CNT_W-1:0] idx_cnt
);
  // R2: a filtered bit may only move to the value its raw input had
  a_r2_filter_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt ^ $past(filt)) & (filt ^ $past(raw))) == 3'b000);

  // R3: in 2X mode a lone phase B edge does not move the position
  a_r3_2x_ignores_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode4x && (filt[1] ^ filt_q[1]) && !(filt[0] ^ filt_q[0])) |=> $stable(pos));

  // R5: a double phase flip leaves the position untouched
  a_r5_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt[0] ^ filt_q[0]) && (filt[1] ^ filt_q[1])) |=> $stable(pos));

  // R6: the position moves by one step or wraps
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != $past(pos)) |->
      (pos == POS_W'($past(pos) + 1'b1) || pos == POS_W'($past(pos) - 1'b1) ||
       pos == '0 || pos == $past(pos_max)));

  // R7: the index count only ever advances by one
  a_r7_idx_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_cnt != $past(idx_cnt)) |-> idx_cnt == CNT_W'($past(idx_cnt) + 1'b1));
endmodule

bind qenc_decoder qenc_decoder_chk #(.POS_W(POS_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode4x(mode4x), .raw(raw), .filt(filt),
  .filt_q(filt_q), .pos(pos), .pos_max(pos_max), .idx_cnt(idx_cnt));

// File: tb/qenc_decoder_tb_top.sv
module qenc_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D = 2;
  localparam int PMAX = 50;

  logic clk = 0, rst_n = 0, enc_a = 0, enc_b = 0, enc_idx = 0;
  logic [3:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq_o;
  int checks = 0, failures = 0;
  bit done = 0;
  int mpos = 0, midx = 0, gst = 0, mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qenc_decoder dut_i (.clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .enc_idx(enc_idx), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o));

  function automatic logic [1:0] gray(int s);
    case (s & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic int wrap_step(int p, bit up);
    if (up) return (p >= PMAX) ? 0 : p + 1;
    return (p == 0) ? PMAX : p - 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic drive_ab(logic [1:0] ab, int hold);
    @(negedge clk); enc_a = ab[1]; enc_b = ab[0];
    repeat (hold) @(negedge clk);
  endtask

  task automatic step(bit up);
    int ns = up ? gst + 1 : gst + 3;
    bit a_ch = gray(gst)[1] != gray(ns)[1];
    gst = ns & 3;
    drive_ab(gray(gst), D + 3);
    if (mode == 1 || a_ch) mpos = wrap_step(mpos, up);
  endtask

  task automatic idx_pulse();
    @(negedge clk); enc_idx = 1; repeat (D + 3) @(negedge clk);
    enc_idx = 0; repeat (D + 3) @(negedge clk);
    midx++;
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8, v); chk("R1 pos", v, 0);
    rd(9, v); chk("R1 idx", v, 0);
    rd(7, v); chk("R1 status", v & 32'h1f, 0);
    chk("R1 irq", irq_o, 0);

    wr(1, D); wr(2, PMAX); wr(0, 1); mode = 1;
    // R2: short glitch rejected, long pulse accepted
    @(negedge clk); enc_a = 1; repeat (D) @(negedge clk); enc_a = 0;
    repeat (D + 4) @(negedge clk);
    rd(8, v); chk("R2 glitch ignored", v, 0);
    @(negedge clk); enc_a = 1; repeat (D + 1) @(negedge clk); enc_a = 0;
    repeat (2) @(negedge clk);
    rd(8, v); chk("R2 pulse D+1 accepted", v, 1);
    repeat (D + 4) @(negedge clk);
    mpos = 0; gst = 0;
    rd(8, v); chk("R2 pulse return", v, 0);

    // R4: forward counting and direction flag
    for (int i = 0; i < 4; i++) step(1);
    rd(8, v); chk("R4 forward 4X", v, mpos);
    rd(7, v); chk("R4 dir up", v[5], 1);
    // R6: wrap below zero and above max
    for (int i = 0; i < 5; i++) step(0);
    rd(8, v); chk("R6 wrap below zero", v, PMAX);
    rd(7, v); chk("R4 dir down", v[5], 0);
    step(1);
    rd(8, v); chk("R6 wrap above max", v, 0);

    // R3: 2X mode counts phase A edges only
    wr(0, 0); mode = 0;
    for (int i = 0; i < 4; i++) step(1);
    rd(8, v); chk("R3 2X forward", v, 2);
    chk("R3 model", mpos, 2);
    wr(0, 1); mode = 1;

    // R5: double flip
    wr(7, 32'h1f);
    gst = (gst + 2) & 3;
    drive_ab(gray(gst), D + 3);
    rd(7, v); chk("R5 error flag", v[4], 1);
    rd(8, v); chk("R5 pos held", v, mpos);

    // R7: index counter
    idx_pulse(); idx_pulse();
    rd(9, v); chk("R7 index count", v, 2);

    // R9: matches
    wr(3, wrap_step(mpos, 1)); wr(4, 3); wr(7, 32'h1f);
    step(1);
    rd(7, v); chk("R9 pos match", v[2:0], 3'b001);
    wr(7, 32'h1f);
    idx_pulse();
    rd(7, v); chk("R9 idx+both match", v[2:0], 3'b110);
    // R10: interrupt enable and clear
    wr(6, 32'h4); @(negedge clk);
    chk("R10 irq set", irq_o, 1);
    wr(7, 32'h4); @(negedge clk);
    chk("R10 irq cleared", irq_o, 0);
    wr(6, 0);

    // R8: velocity window
    wr(5, 400);
    wr(7, 32'h1f);
    v = 0;
    while (v[3] == 0) rd(7, v);
    wr(7, 32'h8);
    for (int i = 0; i < 10; i++) step($urandom_range(0, 1));
    v = 0;
    while (v[3] == 0) rd(7, v);
    rd(10, v); chk("R8 velocity capture", v, 10);

    // random walk against model
    for (int r = 0; r < 150; r++) begin
      if ((r % 30) == 0) begin mode = $urandom_range(0, 1); wr(0, mode); end
      step($urandom_range(0, 1));
      if ((r % 10) == 9) begin rd(8, v); chk("R3 R4 R6 random position", v, mpos); end
    end
    rd(9, v); chk("R7 index unchanged by phases", v, midx);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule